// File: doc/BRIEF.md
# Grouped Interrupt Fan-in Router

This block gathers a bank of level-sensitive interrupt lines from peripheral modules into one shared pending word and drives a small set of upstream interrupt outputs from it. Every source that is high at a clock edge sets its own pending bit. The bit stays set until software clears it by writing a one to that bit position in the status word. A separate enable word gates which pending bits may raise an upstream line.

Each source belongs to one group, and a parameterised map sets which group that is. Each group drives its own upstream output. All of the outputs report through the same status word, so a handler woken by any one output sees every pending source. Software usually clears everything and masks everything at start-up. It then sets or clears single enable bits by read-modify-write.

The register port completes each access in one cycle. Read data is combinational from the addressed register while a read is selected.

Top module: `irq_fanin_router`

## Requirements
- R1: After synchronous reset, the enable word and the pending word both read 0 and every upstream output is low.
- R2: A write to byte offset 0x0 replaces the whole enable word, and a read at offset 0x0 returns its current value.
- R3: A source that is high at a clock edge sets its pending bit at that edge. The bit stays set after the source returns low, until it is cleared.
- R4: A write to byte offset 0x4 clears each pending bit whose written bit is 1. Pending bits whose written bit is 0 are left unchanged.
- R5: If a source is high in the same cycle that its bit is cleared, the set wins and the bit remains 1.
- R6: A read at offset 0x4 returns the raw pending bits, including bits whose enable is 0.
- R7: Upstream output k is high exactly when at least one source in group k is both pending and enabled.
- R8: Pending bits that are masked do not drive any output. If their enable is later set, the output rises without the source having to fire again.
- R9: Reads at any offset other than 0x0 and 0x4 return 0, and writes to those offsets change neither the enable word nor the pending word.
- R10: Writing all ones to offset 0x4 and all zeros to offset 0x0, with all sources low, leaves nothing pending and all outputs low.
- R11: In the default map, source i belongs to group i modulo the number of outputs. With 6 outputs, source 31 therefore drives output 1 and source 13 also drives output 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe for this cycle |
| reg_we | input | 1 | 1 selects a write, 0 selects a read |
| reg_addr | input | ADDR_W (4) | Byte offset: 0x0 is the enable word, 0x4 is the pending word |
| reg_wdata | input | NUM_SRC (32) | Write data |
| reg_rdata | output | NUM_SRC (32) | Read data; 0 when no read is selected or the offset is unmapped |
| src_irq | input | NUM_SRC (32) | Level-sensitive source interrupt lines |
| irq_out | output | NUM_OUT (6) | One upstream interrupt per group |

## Verification
The bound checker watches several properties on every cycle. It checks the reset state and that a write to the enable offset loads the enable word. It checks that pending bits are never lost unless a status write occurs, and that a status write clears exactly the written bits whose source is low. It also checks that a high source always wins over a clear, that unmapped writes leave the enable word unchanged, and that no output rises while no pending bit is enabled. The routing of each group to its own output, raw readback of masked bits, and the quiescent start-up sequence depend on chosen source patterns. Late enabling of a source that is already pending is likewise shown only by the bench scenarios, which compare read data and outputs against a reference model.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int IRQF_NSRC   = 32;
    localparam int IRQF_NOUT   = 6;
    localparam int IRQF_GW     = 3;
    localparam int IRQF_AW     = 4;
    localparam int IRQF_EN_OFS = 0;
    localparam int IRQF_ST_OFS = 4;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_EN   = 2'd1,
        TGT_ST   = 2'd2
    } irqf_tgt_e;

    typedef struct packed {
        irqf_tgt_e tgt;
        logic      wr;
        logic      rd;
    } irqf_acc_t;

    function automatic irqf_tgt_e irqf_decode(input int unsigned ofs);
        if (ofs == IRQF_EN_OFS)      return TGT_EN;
        else if (ofs == IRQF_ST_OFS) return TGT_ST;
        else                         return TGT_NONE;
    endfunction

    function automatic logic [IRQF_NSRC*IRQF_GW-1:0] irqf_default_map();
        logic [IRQF_NSRC*IRQF_GW-1:0] m;
        m = '0;
        for (int i = 0; i < IRQF_NSRC; i++) begin
            m[i*IRQF_GW +: IRQF_GW] = IRQF_GW'(i % IRQF_NOUT);
        end
        return m;
    endfunction

endpackage

// File: rtl/irqf_regfile.sv
module irqf_regfile
    import irqf_pkg::*;
#(
    parameter int NUM_SRC = IRQF_NSRC,
    parameter int ADDR_W  = IRQF_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    input  logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] reg_rdata
);

    irqf_acc_t acc;

    always_comb begin
        acc.tgt = irqf_decode(int'(reg_addr));
        acc.wr  = reg_sel && reg_we;
        acc.rd  = reg_sel && !reg_we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (acc.wr && acc.tgt == TGT_EN) begin
            en_q <= reg_wdata;
        end
    end

    assign clr_mask = (acc.wr && acc.tgt == TGT_ST) ? reg_wdata : '0;

    always_comb begin
        reg_rdata = '0;
        if (acc.rd) begin
            unique case (acc.tgt)
                TGT_EN:  reg_rdata = en_q;
                TGT_ST:  reg_rdata = pend_q;
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqf_pending.sv
module irqf_pending #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] pend_q
);

    // A high source overrides a clear of its own bit in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | src_irq;
        end
    end

endmodule

// File: rtl/irqf_route.sv
module irqf_route #(
    parameter int NUM_SRC = 32,
    parameter int NUM_OUT = 6,
    parameter int GRP_W   = 3,
    parameter logic [NUM_SRC*GRP_W-1:0] GROUP_MAP = '0
) (
    input  logic [NUM_SRC-1:0] pend_q,
    input  logic [NUM_SRC-1:0] en_q,
    output logic [NUM_OUT-1:0] irq_out
);

    logic [NUM_SRC-1:0]              live;
    logic [NUM_OUT-1:0][NUM_SRC-1:0] member;

    assign live = pend_q & en_q;

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            assign member[k][i] = (GROUP_MAP[i*GRP_W +: GRP_W] == GRP_W'(k));
        end
        assign irq_out[k] = |(live & member[k]);
    end

endmodule

// File: rtl/irq_fanin_router.sv
module irq_fanin_router
    import irqf_pkg::*;
#(
    parameter int NUM_SRC = IRQF_NSRC,
    parameter int NUM_OUT = IRQF_NOUT,
    parameter int GRP_W   = IRQF_GW,
    parameter int ADDR_W  = IRQF_AW,
    parameter logic [NUM_SRC*GRP_W-1:0] GROUP_MAP = irqf_default_map()
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] src_irq,
    output logic [NUM_OUT-1:0] irq_out
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] clr_mask;

    irqf_regfile #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend_q    (pend_q),
        .en_q      (en_q),
        .clr_mask  (clr_mask),
        .reg_rdata (reg_rdata)
    );

    irqf_pending #(
        .NUM_SRC (NUM_SRC)
    ) u_pend (
        .clk      (clk),
        .rst      (rst),
        .src_irq  (src_irq),
        .clr_mask (clr_mask),
        .pend_q   (pend_q)
    );

    irqf_route #(
        .NUM_SRC   (NUM_SRC),
        .NUM_OUT   (NUM_OUT),
        .GRP_W     (GRP_W),
        .GROUP_MAP (GROUP_MAP)
    ) u_route (
        .pend_q  (pend_q),
        .en_q    (en_q),
        .irq_out (irq_out)
    );

endmodule

// File: rtl/irqf_checker.sv
module irqf_checker
    import irqf_pkg::*;
#(
    parameter int NUM_SRC = IRQF_NSRC,
    parameter int NUM_OUT = IRQF_NOUT,
    parameter int ADDR_W  = IRQF_AW
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_sel,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_SRC-1:0] reg_wdata,
    input logic [NUM_SRC-1:0] src_irq,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_OUT-1:0] irq_out
);

    logic wr_en, wr_st, wr_other;
    assign wr_en    = reg_sel && reg_we && (int'(reg_addr) == IRQF_EN_OFS);
    assign wr_st    = reg_sel && reg_we && (int'(reg_addr) == IRQF_ST_OFS);
    assign wr_other = reg_sel && reg_we && !wr_en && !wr_st;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0 && pend_q == '0 && irq_out == '0));

    a_r2_enable_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> en_q == $past(reg_wdata));

    a_r3_latched: assert property (@(posedge clk) disable iff (rst)
        !wr_st |=> (pend_q & $past(pend_q)) == $past(pend_q));

    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        wr_st |=> (pend_q & $past(reg_wdata & ~src_irq)) == '0);

    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        src_irq != '0 |=> (pend_q & $past(src_irq)) == $past(src_irq));

    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (pend_q & en_q) == '0 |-> irq_out == '0);

    a_r9_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        wr_other |=> $stable(en_q));

endmodule

bind irq_fanin_router irqf_checker #(
    .NUM_SRC (NUM_SRC),
    .NUM_OUT (NUM_OUT),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .src_irq   (src_irq),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .irq_out   (irq_out)
);

// File: tb/tb_irq_fanin_router.sv
module tb_irq_fanin_router;

    localparam int CLK_P = 10;
    localparam int NS    = 32;
    localparam int NO    = 6;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_sel = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [NS-1:0] reg_wdata = '0;
    logic [NS-1:0] reg_rdata;
    logic [NS-1:0] src_irq = '0;
    logic [NO-1:0] irq_out;

    irq_fanin_router dut (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_irq   (src_irq),
        .irq_out   (irq_out)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        logic [NS-1:0] rd;
        logic [NO-1:0] irq;
        string         tag;
    } exp_t;

    exp_t          scb[$];
    int            total = 0;
    int            bad = 0;
    logic [NS-1:0] m_en = '0;
    logic [NS-1:0] m_pend = '0;
    bit            done = 0;

    function automatic logic [NO-1:0] exp_irq(input logic [NS-1:0] p, input logic [NS-1:0] e);
        logic [NO-1:0] r = '0;
        for (int i = 0; i < NS; i++) if (p[i] && e[i]) r[i % NO] = 1'b1;
        return r;
    endfunction

    function automatic logic [NS-1:0] exp_rd(input int a);
        if (a == 0) return m_en;
        if (a == 4) return m_pend;
        return '0;
    endfunction

    task automatic advance_model(input logic [NS-1:0] clr, input bit ld_en, input logic [NS-1:0] d);
        m_pend = (m_pend & ~clr) | src_irq;
        if (ld_en) m_en = d;
    endtask

    task automatic wr(input int a, input logic [NS-1:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        advance_model((a == 4) ? d : '0, a == 0, d);
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
        advance_model('0, 0, '0);
    endtask

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = AW'(a); reg_wdata = '0;
        scb.push_back('{exp_rd(a), exp_irq(m_pend, m_en), tag});
        advance_model('0, 0, '0);
    endtask

    task automatic set_src(input logic [NS-1:0] v);
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; src_irq = v;
        advance_model('0, 0, '0);
    endtask

    // Monitor: compares the design's outputs with each queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (scb.size() > 0) begin
                exp_t it;
                it = scb.pop_front();
                total++;
                if (reg_rdata !== it.rd || irq_out !== it.irq) begin
                    bad++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             it.tag, reg_rdata, irq_out, it.rd, it.irq);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(0, "R1 enable after reset");
        rd(4, "R1 pending after reset");

        wr(0, 32'hFFFF_FFFF);
        rd(0, "R2 enable all ones");
        wr(0, 32'h0000_0A53);
        rd(0, "R2 enable pattern");

        set_src(32'h0000_0008);
        set_src('0);
        rd(4, "R3 bit 3 latched after source drop");
        rd(4, "R6 masked bit 3 visible, no output");

        rd(0, "R8 read before enable update");
        wr(0, m_en | 32'h0000_0008);
        rd(4, "R8 late enable raises output 3");

        set_src(32'h0000_2081);
        set_src('0);
        wr(0, 32'hFFFF_FFFF);
        rd(4, "R7 groups 0,1,3 routed");

        wr(4, 32'h0000_0008);
        rd(4, "R4 clear bit 3 only");

        set_src(32'h0010_0000);
        wr(4, 32'h0010_0000);
        rd(4, "R5 held source survives clear");
        set_src('0);
        wr(4, 32'h0010_0000);
        rd(4, "R5 clear after source drop");

        wr(8, 32'hFFFF_FFFF);
        wr(12, 32'h0000_0000);
        rd(0, "R9 enable unchanged by unmapped write");
        rd(4, "R9 pending unchanged by unmapped write");
        rd(8, "R9 unmapped read zero");
        rd(12, "R9 unmapped read zero at 0xC");

        wr(4, 32'hFFFF_FFFF);
        wr(0, 32'h0000_0000);
        rd(4, "R10 quiescent pending");
        rd(0, "R10 quiescent enable");

        wr(0, 32'hFFFF_FFFF);
        set_src(32'h8000_0000);
        set_src('0);
        rd(4, "R11 source 31 drives output 1");
        set_src(32'h0000_0020);
        set_src('0);
        rd(4, "R11 source 5 adds output 5");

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule